// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a running clock-calendar and raises an alarm when it reaches a programmed moment. The live time word (seconds, minutes, hours) and live date word (day, month, year) arrive as packed BCD digits. Each word is compared with a stored alarm word one digit at a time. Every digit has its own mask bit, and a masked digit is left out of the comparison. Because of this, an alarm can repeat with no software action, for example at second 30 of every minute, or at every hour on one day.

The comparison is taken only on the cycle in which the one-second update strobe is high. The live words must already hold the new time on that cycle. When every unmasked digit of both words matches, a sticky alarm flag is set. Software clears the flag by writing 1 to it. An enable bit passes the flag to a registered interrupt/wake output. Software programs the alarm words, the two masks, the enable and the status through a small synchronous register port. That port has a registered read path.

Top module: `bcd_alarm_match`

## Requirements
- R1: After synchronous reset, every register reads 0, the flag is 0 and `alarm_irq` is 0.
- R2: The time word packs seconds units in bits 3:0, tens of seconds in 6:4, minutes units in 11:8, tens of minutes in 14:12, hour units in 19:16 and tens of hours in 21:20. The date word packs day units in 3:0, tens of days in 5:4, month units in 11:8, tens of month in bit 12, year units in 19:16 and tens of year in 23:20. On a strobe where every unmasked digit of both words matches, the flag sets at the next clock edge.
- R3: If any unmasked digit differs on the strobe, the flag does not set.
- R4: Time mask bit k (k = 0..5, from seconds units up to tens of hours, in the order of R2) removes time digit k from the comparison, and only that digit.
- R5: Date mask bit k (k = 0..5, from day units up to tens of year, in the order of R2) removes date digit k from the comparison, and only that digit.
- R6: With all twelve digits masked, every strobe sets the flag.
- R7: Without a strobe, a matching time never sets the flag.
- R8: Writing status bit 0 as 1 clears the flag. Writing it as 0 leaves the flag unchanged.
- R9: A clearing write on the same cycle as a matching strobe leaves the flag set.
- R10: `alarm_irq` equals flag AND enable (control bit 0). Both update on the same edge.
- R11: Bit 21 (the PM indicator in 12-hour mode) is part of the tens-of-hours digit, so AM and PM times never match each other.
- R12: Register map: 0 = alarm time, 1 = alarm date, 2 = time mask (6 bits), 3 = date mask (6 bits), 4 = control, 5 = status. Alarm words read back as written. Masks read back only their 6 bits. Bits outside the digit fields of R2 are not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-second update strobe, high while the live words hold the new time |
| now_time | input | 24 | Live BCD time word |
| now_date | input | 24 | Live BCD date word |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| alarm_irq | output | 1 | Interrupt / wake-up request |

## Verification
The bench walks a single mask bit across all six digits of each word. Each mismatching digit is masked once, then its neighbour is masked instead. A mask decoded in the wrong order would fire on the second case or miss the first. It tests a clear that arrives together with a matching strobe; a design that gives the clear priority would drop that alarm. It also holds a matching time without a strobe, which a level-sensitive design would flag. It checks AM against PM and garbage in bits outside the fields, which catches comparators that ignore bit 21 or compare whole nibbles.

// File: rtl/bcd_alarm_match_pkg.sv
package bcd_alarm_match_pkg;

  localparam int DIGITS  = 6;
  localparam int DIGIT_W = 4;
  localparam int WORD_W  = DIGITS * DIGIT_W;

  // live bits of each BCD field; everything else is not compared
  localparam logic [WORD_W-1:0] TIME_FIELDS = 24'h3F7F7F;
  localparam logic [WORD_W-1:0] DATE_FIELDS = 24'hFF1F3F;

  typedef enum logic [2:0] {
    RA_ALM_TIME = 3'd0,
    RA_ALM_DATE = 3'd1,
    RA_TIME_MSK = 3'd2,
    RA_DATE_MSK = 3'd3,
    RA_CTRL     = 3'd4,
    RA_STATUS   = 3'd5
  } reg_addr_e;

endpackage

// File: rtl/bcd_word_match.sv
module bcd_word_match #(
  parameter int DIGITS  = 6,
  parameter int DIGIT_W = 4,
  parameter logic [DIGITS*DIGIT_W-1:0] FIELD_BITS = '1
) (
  input  logic [DIGITS*DIGIT_W-1:0] live_word,
  input  logic [DIGITS*DIGIT_W-1:0] alarm_word,
  input  logic [DIGITS-1:0]         digit_mask,
  output logic                      all_match
);

  logic [DIGITS-1:0] digit_ok;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [DIGIT_W-1:0] sel;
    assign sel = FIELD_BITS[g*DIGIT_W +: DIGIT_W];
    assign digit_ok[g] = digit_mask[g] |
      ((live_word[g*DIGIT_W +: DIGIT_W] & sel) == (alarm_word[g*DIGIT_W +: DIGIT_W] & sel));
  end

  assign all_match = &digit_ok;

endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  input  logic en_next,
  output logic flag_q,
  output logic irq_q
);

  logic flag_d;

  // a new hit wins over a clear in the same cycle
  assign flag_d = hit | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & en_next;
    end
  end

endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_match_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [WORD_W-1:0] now_time,
  input  logic [WORD_W-1:0] now_date,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              alarm_irq
);

  logic [WORD_W-1:0] alm_time, alm_date;
  logic [DIGITS-1:0] time_msk, date_msk;
  logic              irq_en;
  logic              time_ok, date_ok, hit, clr_req, en_next, flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_time <= '0;
      alm_date <= '0;
      time_msk <= '0;
      date_msk <= '0;
      irq_en   <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        RA_ALM_TIME: alm_time <= cfg_wdata[WORD_W-1:0];
        RA_ALM_DATE: alm_date <= cfg_wdata[WORD_W-1:0];
        RA_TIME_MSK: time_msk <= cfg_wdata[DIGITS-1:0];
        RA_DATE_MSK: date_msk <= cfg_wdata[DIGITS-1:0];
        RA_CTRL:     irq_en   <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  bcd_word_match #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .FIELD_BITS(TIME_FIELDS)) u_time_cmp (
    .live_word (now_time),
    .alarm_word(alm_time),
    .digit_mask(time_msk),
    .all_match (time_ok)
  );

  bcd_word_match #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .FIELD_BITS(DATE_FIELDS)) u_date_cmp (
    .live_word (now_date),
    .alarm_word(alm_date),
    .digit_mask(date_msk),
    .all_match (date_ok)
  );

  assign hit     = sec_tick & time_ok & date_ok;
  assign clr_req = cfg_wr & (cfg_addr == RA_STATUS) & cfg_wdata[0];
  assign en_next = (cfg_wr && cfg_addr == RA_CTRL) ? cfg_wdata[0] : irq_en;

  alarm_flag_ctrl u_flag (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .clr    (clr_req),
    .en_next(en_next),
    .flag_q (flag),
    .irq_q  (alarm_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        RA_ALM_TIME: cfg_rdata <= DATA_W'(alm_time);
        RA_ALM_DATE: cfg_rdata <= DATA_W'(alm_date);
        RA_TIME_MSK: cfg_rdata <= DATA_W'(time_msk);
        RA_DATE_MSK: cfg_rdata <= DATA_W'(date_msk);
        RA_CTRL:     cfg_rdata <= DATA_W'(irq_en);
        RA_STATUS:   cfg_rdata <= DATA_W'(flag);
        default:     cfg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/bcd_alarm_match_chk.sv
module bcd_alarm_match_chk #(
  parameter int DIGITS = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              time_ok,
  input logic              date_ok,
  input logic              clr_req,
  input logic [DIGITS-1:0] time_msk,
  input logic [DIGITS-1:0] date_msk,
  input logic              irq_en,
  input logic              flag,
  input logic              alarm_irq
);

  // R2
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    sec_tick && time_ok && date_ok |=> flag);

  // R7
  no_tick_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_tick && !flag |=> !flag);

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req && !(sec_tick && time_ok && date_ok) |=> !flag);

  // R6
  all_masked_fires_chk: assert property (@(posedge clk) disable iff (rst)
    sec_tick && (&time_msk) && (&date_msk) |=> flag);

  // R10
  irq_gating_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_irq == (flag && irq_en));

endmodule

bind bcd_alarm_match bcd_alarm_match_chk #(.DIGITS(bcd_alarm_match_pkg::DIGITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sec_tick (sec_tick),
  .time_ok  (time_ok),
  .date_ok  (date_ok),
  .clr_req  (clr_req),
  .time_msk (time_msk),
  .date_msk (date_msk),
  .irq_en   (irq_en),
  .flag     (flag),
  .alarm_irq(alarm_irq)
);

// File: tb/bcd_alarm_match_tb_top.sv
`timescale 1ns/1ps
module bcd_alarm_match_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic [23:0] now_time = '0;
  logic [23:0] now_date = '0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        alarm_irq;

  always #2.5 clk = ~clk;

  bcd_alarm_match dut_i (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .now_time(now_time), .now_date(now_date),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .alarm_irq(alarm_irq)
  );

  typedef struct {
    bit          is_read;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;
  int       n_vec = 0;
  int       n_bad = 0;
  bit       done  = 0;

  localparam logic [23:0] A_TIME = 24'h123045;
  localparam logic [23:0] A_DATE = 24'h250612;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        sb_item_t it;
        logic [31:0] got;
        it  = sb_q.pop_front();
        got = it.is_read ? cfg_rdata : {31'd0, alarm_irq};
        n_vec++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s %s got=%h exp=%h", it.req, it.is_read ? "rdata" : "irq", got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic tick(input logic [23:0] t, input logic [23:0] d, input bit clr);
    @(negedge clk);
    now_time = t; now_date = d; sec_tick = 1'b1;
    if (clr) begin cfg_wr = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'd1; end
    @(negedge clk); sec_tick = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic exp_irq(input bit e, input string r);
    sb_item_t it;
    it.is_read = 1'b0; it.exp = {31'd0, e}; it.req = r;
    sb_q.push_back(it); -> sb_ev; #0.1;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string r);
    sb_item_t it;
    @(negedge clk); cfg_addr = a;
    @(negedge clk);
    it.is_read = 1'b1; it.exp = e; it.req = r;
    sb_q.push_back(it); -> sb_ev; #0.1;
  endtask

  task automatic clear_flag();
    wr(3'd5, 32'd1);
  endtask

  // watchdog
  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    exp_irq(0, "R1");
    for (int a = 0; a < 6; a++) exp_rd(3'(a), 32'd0, "R1");

    // R12 readback and mask width
    wr(3'd0, 32'h00123045 | 32'h80);
    exp_rd(3'd0, 32'h001230C5, "R12");
    wr(3'd2, 32'hFF);
    exp_rd(3'd2, 32'h3F, "R12");
    wr(3'd2, 32'h0);

    wr(3'd0, {8'd0, A_TIME});
    wr(3'd1, {8'd0, A_DATE});
    wr(3'd4, 32'd1);

    // R3 one digit off
    tick(24'h123044, A_DATE, 0); exp_irq(0, "R3");
    tick(A_TIME, 24'h250613, 0); exp_irq(0, "R3");
    // R2 full match
    tick(A_TIME, A_DATE, 0); exp_irq(1, "R2");
    exp_rd(3'd5, 32'd1, "R2");
    // R8 write of 0 has no effect, write of 1 clears
    wr(3'd5, 32'd0); exp_irq(1, "R8");
    clear_flag(); exp_irq(0, "R8");
    exp_rd(3'd5, 32'd0, "R8");

    // R7 matching words without strobe
    @(negedge clk); now_time = A_TIME; now_date = A_DATE;
    repeat (5) @(negedge clk);
    exp_irq(0, "R7");

    // R4 walk a time mask bit; masked digit differs -> fire, neighbour masked -> no fire
    for (int k = 0; k < 6; k++) begin
      logic [23:0] lt;
      lt = A_TIME ^ (24'h1 << (4 * k));
      wr(3'd2, 32'h1 << k);
      tick(lt, A_DATE, 0); exp_irq(1, "R4");
      clear_flag();
      wr(3'd2, 32'h1 << ((k + 1) % 6));
      tick(lt, A_DATE, 0); exp_irq(0, "R4");
    end
    wr(3'd2, 32'h0);

    // R5 same walk on the date word
    for (int k = 0; k < 6; k++) begin
      logic [23:0] ld;
      ld = A_DATE ^ (24'h1 << (4 * k));
      wr(3'd3, 32'h1 << k);
      tick(A_TIME, ld, 0); exp_irq(1, "R5");
      clear_flag();
      wr(3'd3, 32'h1 << ((k + 1) % 6));
      tick(A_TIME, ld, 0); exp_irq(0, "R5");
    end
    wr(3'd3, 32'h0);

    // R6 everything masked fires on each strobe
    wr(3'd2, 32'h3F); wr(3'd3, 32'h3F);
    tick(24'h000000, 24'h000000, 0); exp_irq(1, "R6");
    clear_flag();
    tick(24'h235959, 24'h991231, 0); exp_irq(1, "R6");
    clear_flag();
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);

    // R9 clear colliding with a match keeps the flag
    tick(A_TIME, A_DATE, 1); exp_irq(1, "R9");
    tick(24'h000000, A_DATE, 1); exp_irq(0, "R9");

    // R10 enable gating
    wr(3'd4, 32'd0);
    tick(A_TIME, A_DATE, 0); exp_irq(0, "R10");
    exp_rd(3'd5, 32'd1, "R10");
    wr(3'd4, 32'd1); exp_irq(1, "R10");
    clear_flag();

    // R11 PM bit is compared
    wr(3'd0, 32'h00210000);
    tick(24'h010000, A_DATE, 0); exp_irq(0, "R11");
    tick(24'h210000, A_DATE, 0); exp_irq(1, "R11");
    clear_flag();

    // R12 bits outside fields ignored
    wr(3'd0, 32'h001230C5);
    tick(A_TIME, A_DATE, 0); exp_irq(1, "R12");
    clear_flag();
    tick(A_TIME | 24'h808080, A_DATE | 24'h00C0C0, 0); exp_irq(1, "R12");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule